// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a data word by a whole number of clock cycles chosen at run time. The delay word is applied as a plain binary number, and the block returns the input from exactly that many cycles earlier. Internally the storage is split into sections whose lengths are successive powers of two, shortest first. A control bit chooses whether its section is part of the data path or is skipped. The selected section lengths add up to the value of the control word.

Every section register advances on every clock, whether or not its section is in use. A control word of zero skips every section, so the output follows the input through multiplexers alone, with no register in the path. A synchronous reset zeroes all stored words, so a freshly reset line emits zeros until real data reaches the output. After the control word changes, the output is guaranteed only once the new delay's number of cycles has elapsed.

Top module: `dly_line`

## Requirements
- R1: With the control word held at value d (0 to 2^NSEG-1, 63 by default) for at least d clock edges, dout equals the din value sampled d rising edges earlier.
- R2: With the control word equal to zero, dout equals din in the same cycle, with no register in between.
- R3: Control bit k (bit 0 is the least significant) switches in a section of exactly 2^k stages. Setting bit k alone gives a delay of 2^k cycles.
- R4: For a control word with several bits set, the delay is the sum of the selected section lengths, which is the binary value of the word. An example is 45 (binary 101101).
- R5: Bypassed sections still shift every cycle. After the control word has been held at zero for at least 2^k edges and is then set to 2^k, dout carries din from 2^k edges earlier from the very first cycle after the change. The value 1 is always correct at once.
- R6: A synchronous active-high reset clears every stage to zero. Directly after reset, with a nonzero control word d, dout is zero until d edges with new input have passed.
- R7: After the control word changes to a new value d, dout is correct again once d clock edges have elapsed under the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears all stages |
| din | input | W | Data word entering the line |
| dly_sel | input | NSEG | Binary delay in cycles; bit k selects the 2^k-stage section |
| dout | output | W | Delayed data word |

## Verification
The bench keeps its own record of past inputs and compares dout against the entry the control word points at. It checks only once the new control value has been held for enough edges, and always for zero.

Zero delay is checked in the same cycle. An implementation that registers the output there would lag by one. Each single-bit control value is visited, so a section with the wrong length, or a swapped bit-to-section mapping, shows up as a wrong delay.

Switching from a long-held zero to a single power of two is checked at once. An implementation that stalls bypassed sections would emit stale words. A post-reset window with a nonzero delay shows whether stale or unreset storage leaks out. The all-ones value and several mixed and random values catch carry-style errors in how the section lengths add up.

// File: rtl/dly_pkg.sv
package dly_pkg;

   // number of stages in section k
   function automatic int sec_len(input int k);
      return 1 << k;
   endfunction

   // largest delay reachable with nseg sections
   function automatic int max_delay(input int nseg);
      return (1 << nseg) - 1;
   endfunction

endpackage

// File: rtl/dly_bypass_mux.sv
module dly_bypass_mux #(
   parameter int W = 8
) (
   input  logic         use_sec,
   input  logic [W-1:0] thru,
   input  logic [W-1:0] skip,
   output logic [W-1:0] y
);
   always_comb begin
      y = use_sec ? thru : skip;
   end
endmodule

// File: rtl/dly_stage_bank.sv
module dly_stage_bank #(
   parameter int W   = 8,
   parameter int LEN = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] feed,
   output logic [W-1:0] last
);
   generate
      if (LEN < 1) begin : g_bad_len
         $error("dly_stage_bank: LEN must be at least 1");
      end

      if (LEN == 1) begin : g_single
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= feed;
         end
         assign last = q;
      end else begin : g_chain
         logic [W-1:0] pipe [LEN];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < LEN; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= feed;
               for (int i = 1; i < LEN; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign last = pipe[LEN-1];
      end
   endgenerate
endmodule

// File: rtl/dly_section.sv
module dly_section #(
   parameter int W   = 8,
   parameter int IDX = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         use_sec,
   input  logic [W-1:0] feed,
   output logic [W-1:0] y
);
   import dly_pkg::*;

   localparam int LEN = sec_len(IDX);

   logic [W-1:0] tail;

   // storage always advances; the mux alone decides whether it counts
   dly_stage_bank #(.W(W), .LEN(LEN)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .feed (feed),
      .last (tail)
   );

   dly_bypass_mux #(.W(W)) u_mux (
      .use_sec (use_sec),
      .thru    (tail),
      .skip    (feed),
      .y       (y)
   );
endmodule

// File: rtl/dly_line.sv
module dly_line #(
   parameter int W    = 8,
   parameter int NSEG = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [W-1:0]    din,
   input  logic [NSEG-1:0] dly_sel,
   output logic [W-1:0]    dout
);
   import dly_pkg::*;

   localparam int MAXD = max_delay(NSEG);

   generate
      if (W < 1) begin : g_bad_w
         $error("dly_line: W must be at least 1");
      end
      if (NSEG < 1 || NSEG > 10) begin : g_bad_nseg
         $error("dly_line: NSEG must lie in 1..10");
      end
      if (MAXD < 1) begin : g_bad_maxd
         $error("dly_line: derived maximum delay is empty");
      end
   endgenerate

   // node[k] feeds section k; node[NSEG] is the line output
   logic [W-1:0] node [NSEG+1];

   assign node[0] = din;

   genvar k;
   generate
      for (k = 0; k < NSEG; k++) begin : g_sec
         dly_section #(.W(W), .IDX(k)) u_sec (
            .clk     (clk),
            .rst     (rst),
            .use_sec (dly_sel[k]),
            .feed    (node[k]),
            .y       (node[k+1])
         );
      end
   endgenerate

   assign dout = node[NSEG];
endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
   parameter int W    = 8,
   parameter int NSEG = 6
) (
   input logic            clk,
   input logic            rst,
   input logic [W-1:0]    din,
   input logic [NSEG-1:0] dly_sel,
   input logic [W-1:0]    dout
);
   localparam int MAXD = (1 << NSEG) - 1;

   // history of inputs seen at rising edges, cleared by reset
   logic [W-1:0]    hist [1:MAXD];
   logic [NSEG-1:0] prev_sel;
   logic [NSEG:0]   held;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 1; i <= MAXD; i++) hist[i] <= '0;
         prev_sel <= dly_sel;
         held     <= (NSEG+1)'(MAXD);
      end else begin
         hist[1] <= din;
         for (int i = 2; i <= MAXD; i++) hist[i] <= hist[i-1];
         prev_sel <= dly_sel;
         if (dly_sel != prev_sel)       held <= (NSEG+1)'(1);
         else if (held < (NSEG+1)'(MAXD)) held <= held + 1'b1;
      end
   end

   logic [W-1:0] want;
   logic         settled;
   always_comb begin
      want    = (dly_sel == '0) ? din : hist[dly_sel];
      settled = (dly_sel == prev_sel) && (held >= {1'b0, dly_sel});
   end

   // R2: zero delay is a transparent path
   p_zero_path_r2: assert property (@(posedge clk) disable iff (rst)
      (dly_sel == '0) |-> (dout == din));

   // R1 / R4 / R7: once settled, output is the input from dly_sel edges ago
   p_exact_delay_r1: assert property (@(posedge clk) disable iff (rst)
      settled |-> (dout == want));

   // R5: the first section always shifts din, so value 1 is right at once
   p_first_shifts_r5: assert property (@(posedge clk) disable iff (rst)
      (dly_sel == NSEG'(1)) |-> (dout == hist[1]));

   // R6: right after reset every stage holds zero
   p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && dly_sel != '0) |-> (dout == '0));
endmodule

bind dly_line dly_line_chk #(.W(W), .NSEG(NSEG)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .din     (din),
   .dly_sel (dly_sel),
   .dout    (dout)
);

// File: tb/dly_line_test.sv
module dly_line_test;
   localparam int W    = 8;
   localparam int N    = 6;
   localparam int MAXD = 63;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] din = '0;
   logic [N-1:0] ctl = '0;
   logic [W-1:0] dout;

   int n_vec = 0;
   int n_bad = 0;
   int held  = 1000;
   logic [W-1:0] h [1:MAXD];

   always #10 clk = ~clk;

   dly_line #(.W(W), .NSEG(N)) uut (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .dly_sel (ctl),
      .dout    (dout)
   );

   function automatic logic [W-1:0] expect_out(input logic [N-1:0] c, input logic [W-1:0] d);
      return (c == '0) ? d : h[c];
   endfunction

   // one cycle: drive at the falling edge, check, then record the edge
   task automatic tick(input logic [N-1:0] c, input logic [W-1:0] d,
                       input bit chk, input bit force_chk, input string tag);
      logic [W-1:0] e;
      @(negedge clk);
      if (c != ctl) held = 0;
      ctl = c;
      din = d;
      #2;
      if (chk && (force_chk || held >= int'(c))) begin
         e = expect_out(c, d);
         n_vec++;
         if (dout !== e) begin
            n_bad++;
            $display("FAIL %s ctl=%0d actual=%h expected=%h", tag, c, dout, e);
         end
      end
      @(posedge clk);
      #1;
      if (rst) begin
         for (int i = 1; i <= MAXD; i++) h[i] = '0;
         held = 1000;
      end else begin
         for (int i = MAXD; i > 1; i--) h[i] = h[i-1];
         h[1] = d;
         if (held < 1000) held++;
      end
   endtask

   task automatic run(input logic [N-1:0] c, input int cycles, input string tag);
      for (int i = 0; i < cycles; i++) tick(c, W'($urandom), 1'b1, 1'b0, tag);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 1; i <= MAXD; i++) h[i] = '0;

      // reset, then a nonzero delay must emit zeros first (R6)
      rst = 1'b1;
      for (int i = 0; i < 3; i++) tick(N'(5), 8'hA5, 1'b0, 1'b0, "R6");
      rst = 1'b0;
      for (int i = 0; i < 5; i++) tick(N'(5), W'($urandom) | 8'h01, 1'b1, 1'b1, "R6 zero after reset");
      run(N'(5), 10, "R6 after fill");

      // zero delay: transparent (R2)
      run(N'(0), 12, "R2");
      tick(N'(0), 8'h00, 1'b1, 1'b0, "R2");
      tick(N'(0), 8'hFF, 1'b1, 1'b0, "R2");

      // each single section (R3)
      for (int k = 0; k < N; k++) run(N'(1 << k), (1 << k) + 6, "R3");

      // maximum and mixed values (R1, R4)
      run(N'(63), 80, "R1 max");
      run(N'(45), 60, "R4 mixed 45");
      run(N'(22), 30, "R4 mixed 22");

      // change mid-stream, recovery after new delay (R7)
      run(N'(45), 50, "R7 before change");
      run(N'(20), 30, "R7 after change");

      // bypassed sections keep shifting (R5)
      run(N'(0), 40, "R5 hold zero");
      tick(N'(32), W'($urandom), 1'b1, 1'b1, "R5 switch to 32");
      for (int i = 0; i < 5; i++) tick(N'(32), W'($urandom), 1'b1, 1'b1, "R5 after 32");
      run(N'(0), 10, "R5 hold zero");
      tick(N'(8), W'($urandom), 1'b1, 1'b1, "R5 switch to 8");
      run(N'(0), 3, "R5 hold zero");
      tick(N'(1), W'($urandom), 1'b1, 1'b1, "R5 switch to 1");
      tick(N'(1), W'($urandom), 1'b1, 1'b1, "R5 stay 1");

      // random control values (R1)
      for (int r = 0; r < 8; r++) begin
         logic [N-1:0] c;
         c = N'($urandom_range(1, MAXD));
         run(c, int'(c) + 10, "R1 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule